// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional equal-compare branches while the branch is still in the decode stage of a five-stage pipeline. It receives the decode-stage instruction word and the address of the following instruction from the fetch/decode register, plus the two operand values read from the register file. A private adder forms the branch target, and a private equality comparator decides the branch, so the execute-stage ALU is never involved. From these it drives the program-counter redirect, the next fetch address, and a flush request for the fetch/decode register.

Two policies are available. In bubble policy every branch costs exactly one cycle: the word being fetched behind the branch is replaced by a NOP and the fetch restarts at either the target or the sequential address. In slot policy the word behind the branch always executes, no NOP is inserted, and only a taken branch redirects the fetch. The policy input is captured while reset is held and is ignored afterwards.

Top module: `ebr_unit`

## Requirements
- R1: Only an instruction whose bits 31:26 equal 6'b000100 is a branch; any other word leaves `pc_redirect_o` and `ifid_flush_o` at 0, keeps `br_taken_o` at 0 and sets `next_pc_o` to `fetch_pc_plus4_i`.
- R2: `br_target_o` always equals `id_pc_plus4_i` plus the sign-extended bits 15:0 shifted left by two, modulo 2^32, for every instruction word.
- R3: `br_taken_o` is 1 exactly when the word is a branch and `rs_val_i` equals `rt_val_i` across all 32 bits.
- R4: Slot policy (mode 1), taken branch: `pc_redirect_o` = 1, `next_pc_o` = target, `ifid_flush_o` = 0.
- R5: Slot policy, not-taken branch: `pc_redirect_o` = 0, `next_pc_o` = `fetch_pc_plus4_i`, `ifid_flush_o` = 0.
- R6: Bubble policy (mode 0), taken branch: `pc_redirect_o` = 1, `next_pc_o` = target, `ifid_flush_o` = 1.
- R7: Bubble policy, not-taken branch: `pc_redirect_o` = 1, `next_pc_o` = `id_pc_plus4_i` (the word after the branch is fetched again), `ifid_flush_o` = 1.
- R8: While `rst_n` is 0, `pc_redirect_o` and `ifid_flush_o` are 0 and `next_pc_o` equals `fetch_pc_plus4_i`, whatever the instruction.
- R9: The policy is taken from `slot_mode_i` at clock edges with `rst_n` low; changing `slot_mode_i` after reset has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; policy is captured while low |
| slot_mode_i | input | 1 | Policy select: 1 slot policy, 0 bubble policy |
| id_pc_plus4_i | input | 32 | Address following the decode-stage instruction |
| id_instr_i | input | 32 | Decode-stage instruction word |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| fetch_pc_plus4_i | input | 32 | Sequential address following the word being fetched |
| br_taken_o | output | 1 | Branch decision |
| br_target_o | output | 32 | Computed branch target |
| pc_redirect_o | output | 1 | Load `next_pc_o` into the PC instead of the sequential value |
| next_pc_o | output | 32 | Next fetch address |
| ifid_flush_o | output | 1 | Replace the fetch/decode register contents with a NOP |

## Verification
Every result apart from the captured policy is combinational in the present inputs, so each is due in the same cycle as its stimulus; the bench changes inputs on the falling edge and reads outputs two nanoseconds later, well before the next rising edge. The policy capture has a latency of one rising edge with reset low, so the bench holds reset for several edges before the first branch and checks the policy-change cases only after at least one full cycle with reset high. Both policies replay the same stimulus table, so each branch word is judged under both rule sets.

// File: rtl/ebr_pkg.sv
package ebr_pkg;

   localparam int unsigned OPC_W = 6;
   localparam logic [OPC_W-1:0] OPC_BRANCH_EQ = 6'b000100;

   typedef enum logic {
      POL_BUBBLE = 1'b0,
      POL_SLOT   = 1'b1
   } br_policy_e;

   // Comparator implementation variants
   localparam int unsigned CMP_MAGNITUDE = 0;
   localparam int unsigned CMP_XOR_TREE  = 1;

endpackage

// File: rtl/ebr_target_add.sv
module ebr_target_add #(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned OFFSET_W = 16,
   parameter int unsigned SHIFT    = 2
) (
   input  logic [XLEN-1:0]     pc4_i,
   input  logic [OFFSET_W-1:0] offset_i,
   output logic [XLEN-1:0]     target_o
);

   localparam int unsigned EXT_W = XLEN - OFFSET_W - SHIFT;

   initial begin
      assert (XLEN > OFFSET_W + SHIFT)
         else $fatal(1, "ebr_target_add: offset plus shift must fit inside XLEN");
   end

   logic [XLEN-1:0] disp;

   generate
      if (SHIFT == 0) begin : g_noshift
         assign disp = {{EXT_W{offset_i[OFFSET_W-1]}}, offset_i};
      end else begin : g_shift
         assign disp = {{EXT_W{offset_i[OFFSET_W-1]}}, offset_i, {SHIFT{1'b0}}};
      end
   endgenerate

   assign target_o = pc4_i + disp;

endmodule

// File: rtl/ebr_eq_cmp.sv
module ebr_eq_cmp
   import ebr_pkg::*;
#(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned STYLE = CMP_XOR_TREE
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic             eq_o
);

   initial begin
      assert (STYLE == CMP_MAGNITUDE || STYLE == CMP_XOR_TREE)
         else $fatal(1, "ebr_eq_cmp: unknown STYLE");
      assert (WIDTH > 0) else $fatal(1, "ebr_eq_cmp: WIDTH must be non-zero");
   end

   generate
      if (STYLE == CMP_XOR_TREE) begin : g_xor
         logic [WIDTH-1:0] diff;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign diff[i] = a_i[i] ^ b_i[i];
         end
         assign eq_o = ~|diff;
      end else begin : g_mag
         assign eq_o = (a_i == b_i);
      end
   endgenerate

endmodule

// File: rtl/ebr_policy.sv
module ebr_policy
   import ebr_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slot_mode_i,
   input  logic            is_branch_i,
   input  logic            taken_i,
   input  logic [XLEN-1:0] target_i,
   input  logic [XLEN-1:0] id_pc4_i,
   input  logic [XLEN-1:0] fetch_pc4_i,
   output logic            redirect_o,
   output logic [XLEN-1:0] next_pc_o,
   output logic            flush_o
);

   br_policy_e policy_q;

   // Policy is loaded on every edge while reset is held, then frozen
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         policy_q <= slot_mode_i ? POL_SLOT : POL_BUBBLE;
      end
   end

   always_comb begin
      redirect_o = 1'b0;
      flush_o    = 1'b0;
      next_pc_o  = fetch_pc4_i;
      if (rst_n && is_branch_i) begin
         if (policy_q == POL_SLOT) begin
            redirect_o = taken_i;
            if (taken_i) next_pc_o = target_i;
         end else begin
            redirect_o = 1'b1;
            flush_o    = 1'b1;
            next_pc_o  = taken_i ? target_i : id_pc4_i;
         end
      end
   end

   // R9: policy does not move once reset has been released
   a_r9_policy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && $past(rst_n)) |-> $stable(policy_q));

   // R6/R7: bubble policy always flushes and redirects on a branch
   a_r6_bubble_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (is_branch_i && policy_q == POL_BUBBLE) |-> (flush_o && redirect_o));

   // R7: not-taken branch under bubble policy refetches the following word
   a_r7_refetch: assert property (@(posedge clk) disable iff (!rst_n)
      (is_branch_i && !taken_i && policy_q == POL_BUBBLE) |-> (next_pc_o == id_pc4_i));

   // R4: slot policy never flushes, taken branch goes to target
   a_r4_slot_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (is_branch_i && taken_i && policy_q == POL_SLOT) |-> (!flush_o && next_pc_o == target_i));

   // R5: slot policy, not taken: sequential flow untouched
   a_r5_slot_fallthru: assert property (@(posedge clk) disable iff (!rst_n)
      (is_branch_i && !taken_i && policy_q == POL_SLOT)
         |-> (!flush_o && !redirect_o && next_pc_o == fetch_pc4_i));

endmodule

// File: rtl/ebr_unit.sv
module ebr_unit
   import ebr_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned REG_W     = 5,
   parameter int unsigned OFFSET_W  = 16,
   parameter int unsigned SHIFT     = 2,
   parameter int unsigned CMP_STYLE = CMP_XOR_TREE
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slot_mode_i,
   input  logic [XLEN-1:0] id_pc_plus4_i,
   input  logic [XLEN-1:0] id_instr_i,
   input  logic [XLEN-1:0] rs_val_i,
   input  logic [XLEN-1:0] rt_val_i,
   input  logic [XLEN-1:0] fetch_pc_plus4_i,
   output logic            br_taken_o,
   output logic [XLEN-1:0] br_target_o,
   output logic            pc_redirect_o,
   output logic [XLEN-1:0] next_pc_o,
   output logic            ifid_flush_o
);

   localparam int unsigned OPC_LSB = XLEN - OPC_W;
   localparam int unsigned RS_LSB  = OPC_LSB - REG_W;
   localparam int unsigned RT_LSB  = RS_LSB - REG_W;

   initial begin
      assert (RT_LSB >= OFFSET_W)
         else $fatal(1, "ebr_unit: opcode, register and offset fields overlap");
   end

   logic [OPC_W-1:0]    opcode;
   logic [OFFSET_W-1:0] offset;
   logic                is_branch;
   logic                ops_equal;

   assign opcode    = id_instr_i[XLEN-1:OPC_LSB];
   assign offset    = id_instr_i[OFFSET_W-1:0];
   assign is_branch = (opcode == OPC_BRANCH_EQ);

   ebr_target_add #(
      .XLEN(XLEN), .OFFSET_W(OFFSET_W), .SHIFT(SHIFT)
   ) u_add (
      .pc4_i(id_pc_plus4_i), .offset_i(offset), .target_o(br_target_o)
   );

   ebr_eq_cmp #(
      .WIDTH(XLEN), .STYLE(CMP_STYLE)
   ) u_cmp (
      .a_i(rs_val_i), .b_i(rt_val_i), .eq_o(ops_equal)
   );

   assign br_taken_o = is_branch & ops_equal;

   ebr_policy #(
      .XLEN(XLEN)
   ) u_pol (
      .clk(clk), .rst_n(rst_n), .slot_mode_i(slot_mode_i),
      .is_branch_i(is_branch), .taken_i(br_taken_o), .target_i(br_target_o),
      .id_pc4_i(id_pc_plus4_i), .fetch_pc4_i(fetch_pc_plus4_i),
      .redirect_o(pc_redirect_o), .next_pc_o(next_pc_o), .flush_o(ifid_flush_o)
   );

   // R1: non-branch words leave the fetch path alone
   a_r1_nonbranch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (id_instr_i[XLEN-1:OPC_LSB] != OPC_BRANCH_EQ)
         |-> (!pc_redirect_o && !ifid_flush_o && !br_taken_o && next_pc_o == fetch_pc_plus4_i));

   // R3: a taken decision implies equal operands
   a_r3_taken_equal: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken_o |-> (rs_val_i == rt_val_i));

   // R4/R6: a redirect to anywhere but the sequential address is the target
   a_r2_redirect_target: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_redirect_o && br_taken_o) |-> (next_pc_o == br_target_o));

endmodule

// File: tb/ebr_unit_test.sv
module ebr_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slot_mode_i = 1'b1;
   logic [31:0] id_pc_plus4_i = '0;
   logic [31:0] id_instr_i = '0;
   logic [31:0] rs_val_i = '0;
   logic [31:0] rt_val_i = '0;
   logic [31:0] fetch_pc_plus4_i = '0;
   logic        br_taken_o;
   logic [31:0] br_target_o;
   logic        pc_redirect_o;
   logic [31:0] next_pc_o;
   logic        ifid_flush_o;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   ebr_unit uut (
      .clk(clk), .rst_n(rst_n), .slot_mode_i(slot_mode_i),
      .id_pc_plus4_i(id_pc_plus4_i), .id_instr_i(id_instr_i),
      .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
      .fetch_pc_plus4_i(fetch_pc_plus4_i),
      .br_taken_o(br_taken_o), .br_target_o(br_target_o),
      .pc_redirect_o(pc_redirect_o), .next_pc_o(next_pc_o),
      .ifid_flush_o(ifid_flush_o)
   );

   typedef struct packed {
      logic [31:0] instr;
      logic [31:0] idpc4;
      logic [31:0] fpc4;
      logic [31:0] rs;
      logic [31:0] rt;
      logic        tk;
      logic [31:0] tgt;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{32'h1022_0003, 32'h0000_0100, 32'h0000_0104, 32'h5,         32'h5,         1'b1, 32'h0000_010C},
      '{32'h1022_FFFF, 32'h0000_0200, 32'h0000_0204, 32'h7,         32'h8,         1'b0, 32'h0000_01FC},
      '{32'h1022_FFFE, 32'h0000_1000, 32'h0000_1004, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, 32'h0000_0FF8},
      '{32'h1022_7FFF, 32'h0000_0000, 32'h0000_0004, 32'h0,         32'h0,         1'b1, 32'h0001_FFFC},
      '{32'h1022_8000, 32'h0000_0004, 32'h0000_0008, 32'h1,         32'h8000_0001, 1'b0, 32'hFFFE_0004},
      '{32'h0232_8020, 32'h0000_0300, 32'h0000_0304, 32'h9,         32'h9,         1'b0, 32'hFFFE_0380},
      '{32'h1422_0003, 32'h0000_0100, 32'h0000_0104, 32'h3,         32'h3,         1'b0, 32'h0000_010C},
      '{32'h8C22_0010, 32'h0000_0040, 32'h0000_0044, 32'h2,         32'h2,         1'b0, 32'h0000_0080},
      '{32'h1022_0002, 32'hFFFF_FFFC, 32'h0000_0000, 32'h3,         32'h3,         1'b1, 32'h0000_0004}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      @(negedge clk);
      id_instr_i       = v.instr;
      id_pc_plus4_i    = v.idpc4;
      fetch_pc_plus4_i = v.fpc4;
      rs_val_i         = v.rs;
      rt_val_i         = v.rt;
      #2;
   endtask

   // Expected outputs derived from the requirements for a given policy
   task automatic check_vec(input vec_t v, input logic slot);
      logic br;
      string rq;
      br = (v.instr[31:26] == 6'b000100);
      chk("R2", "target", br_target_o, v.tgt);
      chk("R3", "taken", {31'b0, br_taken_o}, {31'b0, v.tk});
      if (!br) begin
         chk("R1", "redirect", {31'b0, pc_redirect_o}, 32'd0);
         chk("R1", "flush", {31'b0, ifid_flush_o}, 32'd0);
         chk("R1", "next_pc", next_pc_o, v.fpc4);
      end else if (slot) begin
         rq = v.tk ? "R4" : "R5";
         chk(rq, "redirect", {31'b0, pc_redirect_o}, {31'b0, v.tk});
         chk(rq, "flush", {31'b0, ifid_flush_o}, 32'd0);
         chk(rq, "next_pc", next_pc_o, v.tk ? v.tgt : v.fpc4);
      end else begin
         rq = v.tk ? "R6" : "R7";
         chk(rq, "redirect", {31'b0, pc_redirect_o}, 32'd1);
         chk(rq, "flush", {31'b0, ifid_flush_o}, 32'd1);
         chk(rq, "next_pc", next_pc_o, v.tk ? v.tgt : v.idpc4);
      end
   endtask

   task automatic do_reset(input logic slot);
      @(negedge clk);
      rst_n = 1'b0;
      slot_mode_i = slot;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R8: reset holds the fetch path, even with a taken branch present
      drive(VECS[0]);
      repeat (2) @(negedge clk);
      #2;
      chk("R8", "redirect in reset", {31'b0, pc_redirect_o}, 32'd0);
      chk("R8", "flush in reset", {31'b0, ifid_flush_o}, 32'd0);
      chk("R8", "next_pc in reset", next_pc_o, VECS[0].fpc4);

      // Slot policy pass over the table
      do_reset(1'b1);
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         check_vec(VECS[i], 1'b1);
      end

      // R9: switching the mode pin without reset changes nothing
      slot_mode_i = 1'b0;
      repeat (2) @(negedge clk);
      drive(VECS[0]);
      chk("R9", "flush after pin change", {31'b0, ifid_flush_o}, 32'd0);
      drive(VECS[1]);
      chk("R9", "redirect after pin change", {31'b0, pc_redirect_o}, 32'd0);
      chk("R9", "next_pc after pin change", next_pc_o, VECS[1].fpc4);

      // Bubble policy pass over the table
      do_reset(1'b0);
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         check_vec(VECS[i], 1'b0);
      end

      // R9: pin change to slot after reset is ignored
      slot_mode_i = 1'b1;
      repeat (2) @(negedge clk);
      drive(VECS[1]);
      chk("R9", "flush stays bubble", {31'b0, ifid_flush_o}, 32'd1);
      chk("R9", "refetch stays bubble", next_pc_o, VECS[1].idpc4);

      // R8: reset reasserted mid-run masks a branch again
      @(negedge clk);
      rst_n = 1'b0;
      drive(VECS[2]);
      chk("R8", "flush on re-reset", {31'b0, ifid_flush_o}, 32'd0);
      chk("R8", "next_pc on re-reset", next_pc_o, VECS[2].fpc4);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule